// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block serves one read request issued by a group of lanes against a word-interleaved scratchpad split into 32 single-port banks. Each lane brings an enable bit and a word address. The low five address bits pick the bank and the upper bits pick the row inside it. The block looks for lanes that collide in a bank. It then issues one access round per clock cycle until every enabled lane has its word.

Within a round, each bank takes the lowest-numbered lane still waiting on it. Every other waiting lane that asks for that same word is served in the same round. A conflict therefore costs cycles only when one bank holds several different requested words. The result is written into a per-lane data register together with a per-lane valid flag. A one-cycle completion pulse marks the point at which the whole request has been answered.

The banks are preloaded with a fixed content pattern so that every read has a known value. The block has no write path.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address `a` selects bank `a mod 32` (address bits [4:0]) and row `a >> 5`. With 10-bit addresses and 32-bit data, word `a` holds `((a << 16) | a) xor 0xC3C30000`, and an enabled lane receives exactly that value.
- R2: When every enabled lane falls in a different bank, the request takes a single round, and `done` is high in the second cycle after the acceptance edge.
- R3: When n enabled lanes ask for n different words of one bank, the block takes n rounds.
- R4: Lanes that ask for the identical word share one round, and each of them receives the word.
- R5: The round count equals the largest number of distinct requested addresses in any one bank. `done` is a single-cycle pulse that rises on clock edge rounds+1, counting the acceptance edge as edge 0.
- R6: A lane whose enable is low causes no round, ends with `rd_valid` low and `rd_data` zero, and does not change the latency. A request with no enabled lane completes one edge after acceptance.
- R7: `req_start` is accepted only when the block is idle, which includes the cycle in which `done` is high. A pulse while a request is in flight is ignored and changes neither the latency nor the results.
- R8: Acceptance clears all `rd_valid` and `rd_data`. While a request runs, `rd_valid` bits only set. After `done`, the results hold until the next accepted request.
- R9: While in reset and right after it, `done` is low and every `rd_valid` bit is low.
- R10: A pattern whose lanes all use different multiples of 32 as addresses sends every lane to bank 0 and takes 32 rounds.
- R11: Inside a bank, waiting lanes are served in ascending lane order. The data of round r appears on clock edge r+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a request; sampled only while idle |
| lane_valid | input | LANES | Per-lane enable, sampled at acceptance |
| lane_addr | input | LANES x ADDR_W | Per-lane word address, sampled at acceptance |
| rd_valid | output | LANES | Lane result present |
| rd_data | output | LANES x DATA_W | Lane result word |
| done | output | 1 | One-cycle pulse when all enabled lanes are answered |

## Verification
Every result has a due cycle fixed by the round count. For a request needing r rounds, the data of round k appears on edge k+1 after the acceptance edge, and `done` appears on edge r+1. The bench computes r itself by counting distinct addresses per bank. It drives inputs on falling edges and samples on falling edges. It counts edges from acceptance up to `done` and compares that count with r+1. For the all-in-bank-0 pattern it also checks `rd_valid` on each edge, expecting it to grow by exactly one lane in ascending order. Holding of the results is checked two cycles after `done`, and ignored start pulses are applied in the middle of a run.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int NUM_BANKS = 32;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Fixed preload content of the scratchpad, indexed by word address.
    function automatic logic [31:0] preload_word(input logic [31:0] word_addr);
        return (word_addr * 32'h0001_0001) ^ 32'hC3C3_0000;
    endfunction

endpackage

// File: rtl/bcs_bank_ram.sv
module bcs_bank_ram
    import bcs_pkg::*;
#(
    parameter int ROW_W   = 5,
    parameter int DATA_W  = 32,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int r = 0; r < DEPTH; r++) begin
            mem[r] = DATA_W'(preload_word(32'(r * NUM_BANKS + BANK_ID)));
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= mem[rd_row];
        end
    end

endmodule

// File: rtl/bcs_bank_pick.sv
module bcs_bank_pick
    import bcs_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 10,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    output logic                         hit,
    output logic [ROW_W-1:0]             row,
    output logic [LANES-1:0]             serve
);
    logic [ADDR_W-1:0] leader;

    // Lowest-numbered pending lane mapped to this bank leads the round.
    always_comb begin
        hit    = 1'b0;
        leader = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!hit && pending[l] && (addr[l][BANK_W-1:0] == BANK_W'(BANK_ID))) begin
                hit    = 1'b1;
                leader = addr[l];
            end
        end
    end

    // Every pending lane asking for the leader's word rides along.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            serve[l] = hit && pending[l] && (addr[l] == leader);
        end
    end

    assign row = leader[ADDR_W-1:BANK_W];

endmodule

// File: rtl/bcs_router.sv
module bcs_router
    import bcs_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int DATA_W = 32
) (
    input  logic [LANES-1:0][BANK_W-1:0]    lane_bank,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_word,
    output logic [LANES-1:0][DATA_W-1:0]    lane_word
);
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_word[l] = bank_word[lane_bank[l]];
        end
    end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import bcs_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_start,
    input  logic [LANES-1:0]             lane_valid,
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]             rd_valid,
    output logic [LANES-1:0][DATA_W-1:0] rd_data,
    output logic                         done
);
    localparam int ROW_W = ADDR_W - BANK_W;

    run_state_e                        state;
    logic                              running;
    logic [LANES-1:0]                  pending;
    logic [LANES-1:0]                  served_q;
    logic [LANES-1:0]                  serve_all;
    logic [LANES-1:0][ADDR_W-1:0]      addr_q;
    logic [LANES-1:0][BANK_W-1:0]      lane_bank;
    logic [LANES-1:0][DATA_W-1:0]      routed;

    logic [NUM_BANKS-1:0]              bank_hit;
    logic [NUM_BANKS-1:0]              bank_en;
    logic [NUM_BANKS-1:0][ROW_W-1:0]   bank_row;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_word;
    logic [NUM_BANKS-1:0][LANES-1:0]   bank_serve;

    assign running = (state == ST_RUN);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bcs_bank_pick #(
            .LANES   (LANES),
            .ADDR_W  (ADDR_W),
            .BANK_ID (b)
        ) u_pick (
            .pending (pending),
            .addr    (addr_q),
            .hit     (bank_hit[b]),
            .row     (bank_row[b]),
            .serve   (bank_serve[b])
        );

        assign bank_en[b] = running && bank_hit[b];

        bcs_bank_ram #(
            .ROW_W   (ROW_W),
            .DATA_W  (DATA_W),
            .BANK_ID (b)
        ) u_ram (
            .clk     (clk),
            .rd_en   (bank_en[b]),
            .rd_row  (bank_row[b]),
            .rd_word (bank_word[b])
        );
    end

    always_comb begin
        serve_all = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            serve_all = serve_all | bank_serve[b];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_bank
        assign lane_bank[l] = addr_q[l][BANK_W-1:0];
    end

    bcs_router #(
        .LANES  (LANES),
        .DATA_W (DATA_W)
    ) u_router (
        .lane_bank (lane_bank),
        .bank_word (bank_word),
        .lane_word (routed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pending  <= '0;
            served_q <= '0;
            addr_q   <= '0;
            rd_valid <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_start) begin
                        addr_q   <= lane_addr;
                        pending  <= lane_valid;
                        served_q <= '0;
                        rd_valid <= '0;
                        rd_data  <= '0;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (served_q[l]) begin
                            rd_data[l] <= routed[l];
                        end
                    end
                    rd_valid <= rd_valid | served_q;
                    if (pending != '0) begin
                        pending  <= pending & ~serve_all;
                        served_q <= serve_all;
                    end else begin
                        served_q <= '0;
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_start,
    input logic                         running,
    input logic [LANES-1:0]             lane_valid,
    input logic [LANES-1:0]             pending,
    input logic [LANES-1:0][ADDR_W-1:0] addr_q,
    input logic [LANES-1:0]             rd_valid,
    input logic [LANES-1:0][DATA_W-1:0] rd_data,
    input logic                         done
);
    logic             rst_q;
    logic             accept;
    logic [LANES-1:0] acc_mask;

    assign accept = req_start && !running;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            acc_mask <= '0;
        end else if (accept) begin
            acc_mask <= lane_valid;
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst) rst_q |-> (!done && rd_valid == '0)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst) done |-> (pending == '0 && !running)); // R5
    AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst) (rd_valid & ~acc_mask) == '0); // R6
    AST_VALID_GROWS: assert property (@(posedge clk) disable iff (rst) running |=> ((rd_valid & $past(rd_valid)) == $past(rd_valid))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!running && !req_start) |=> ($stable(rd_data) && $stable(rd_valid))); // R8
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst) running |=> $stable(addr_q)); // R7

endmodule

bind bank_conflict_serializer bcs_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_start  (req_start),
    .running    (running),
    .lane_valid (lane_valid),
    .pending    (pending),
    .addr_q     (addr_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .done       (done)
);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 32;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         req_start = 1'b0;
    logic [LANES-1:0]             lane_valid = '0;
    logic [LANES-1:0][ADDR_W-1:0] lane_addr = '0;
    logic [LANES-1:0]             rd_valid;
    logic [LANES-1:0][DATA_W-1:0] rd_data;
    logic                         done;

    logic [LANES-1:0]             st_valid;
    logic [LANES-1:0][ADDR_W-1:0] st_addr;
    logic [31:0]                  seed = 32'h1357_9BDF;

    int checks = 0;
    int errors = 0;

    bank_conflict_serializer #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .req_start  (req_start),
        .lane_valid (lane_valid),
        .lane_addr  (lane_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int a);
        return ((a << 16) | a) ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [31:0] next_rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Largest count of distinct enabled addresses sharing one bank.
    function automatic int model_rounds();
        int best = 0;
        for (int b = 0; b < 32; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                if (st_valid[l] && (int'(st_addr[l]) % 32) == b) begin
                    bit dup = 1'b0;
                    for (int j = 0; j < l; j++) begin
                        if (st_valid[j] && st_addr[j] == st_addr[l]) dup = 1'b1;
                    end
                    if (!dup) cnt++;
                end
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    task automatic run_req(input int exp_rounds, input string lat_tag,
                           input string dat_tag, input bit poke);
        int rounds;
        int cyc;
        bit seen;
        logic [LANES-1:0]             snap_v;
        logic [LANES-1:0][DATA_W-1:0] snap_d;
        rounds = (exp_rounds < 0) ? model_rounds() : exp_rounds;
        if (exp_rounds >= 0) begin
            check(model_rounds() == exp_rounds, lat_tag, "model rounds",
                  model_rounds(), exp_rounds);
        end
        @(negedge clk);
        lane_valid = st_valid;
        lane_addr  = st_addr;
        req_start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_start = 1'b0;
        cyc  = 0;
        seen = 1'b0;
        while (!seen && cyc < 80) begin
            if (poke && cyc == 1) begin
                req_start  = 1'b1;
                lane_addr  = ~st_addr;
                lane_valid = '1;
            end else if (poke && cyc == 2) begin
                req_start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (done) seen = 1'b1;
        end
        req_start = 1'b0;
        check(seen && cyc == rounds + 1, lat_tag, "done edge", cyc, rounds + 1);
        for (int l = 0; l < LANES; l++) begin
            if (st_valid[l]) begin
                check(rd_valid[l] && rd_data[l] == exp_word(int'(st_addr[l])), dat_tag,
                      $sformatf("lane %0d data", l), rd_data[l], exp_word(int'(st_addr[l])));
            end else begin
                check(!rd_valid[l] && rd_data[l] == '0, "R6",
                      $sformatf("idle lane %0d", l), {rd_valid[l], rd_data[l]}, 0);
            end
        end
        snap_v = rd_valid;
        snap_d = rd_data;
        @(posedge clk);
        @(negedge clk);
        check(!done, "R5", "done width", done, 0);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check(rd_valid == snap_v && rd_data == snap_d, "R8", "hold after done",
              rd_valid, snap_v);
    endtask

    // All lanes into bank 0: one lane per round in ascending order.
    task automatic run_bank0_serial();
        logic [63:0] exp_mask;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(l * 32);
        st_valid   = '1;
        lane_valid = st_valid;
        lane_addr  = st_addr;
        req_start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_start = 1'b0;
        for (int m = 1; m <= 33; m++) begin
            @(posedge clk);
            @(negedge clk);
            exp_mask = (m >= 2) ? ((64'd1 << (m - 1)) - 64'd1) : 64'd0;
            check(rd_valid == exp_mask[LANES-1:0], "R11", $sformatf("edge %0d mask", m),
                  rd_valid, exp_mask[LANES-1:0]);
            check(done == (m == 33), "R10", $sformatf("edge %0d done", m), done, m == 33);
        end
        for (int l = 0; l < LANES; l++) begin
            check(rd_data[l] == exp_word(l * 32), "R10", $sformatf("lane %0d data", l),
                  rd_data[l], exp_word(l * 32));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && rd_valid == '0, "R9", "in reset", {done, rd_valid}, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!done && rd_valid == '0, "R9", "after reset", {done, rd_valid}, 0);

        // R1 / R2: one lane per bank, several bases
        for (int base = 0; base < 1024; base += 231) begin
            for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(base + l);
            st_valid = '1;
            run_req(1, "R2", "R1", 1'b0);
        end

        // R4: all lanes on one word
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(100);
        st_valid = '1;
        run_req(1, "R4", "R4", 1'b0);

        // R4: lane pairs share a word
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(64 + l / 2);
        run_req(1, "R4", "R4", 1'b0);

        // R3: stride 2 gives two words per used bank
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(2 * l);
        run_req(2, "R3", "R3", 1'b0);

        // R3: five distinct words in bank 0
        st_valid = '0;
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(32 * (l % 5));
        for (int l = 0; l < 5; l++) st_valid[l] = 1'b1;
        run_req(5, "R3", "R3", 1'b0);

        // R5: mix of broadcast and conflict in bank 0
        st_valid = '1;
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(l);
        for (int l = 0; l < 4; l++) st_addr[l] = ADDR_W'(32);
        st_addr[4] = ADDR_W'(64);
        st_addr[5] = ADDR_W'(64);
        st_addr[6] = ADDR_W'(0);
        run_req(3, "R5", "R4", 1'b0);

        // R6: nothing enabled, then colliding addresses on disabled lanes
        st_valid = '0;
        run_req(0, "R6", "R6", 1'b0);
        for (int l = 0; l < LANES; l++) begin
            st_addr[l]  = (l % 2 == 1) ? ADDR_W'(l) : ADDR_W'(32 * l);
            st_valid[l] = (l % 2 == 1);
        end
        run_req(1, "R6", "R6", 1'b0);

        // R10 / R11: every lane in bank 0
        run_bank0_serial();
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(32 * l + 5);
        st_valid = '1;
        run_req(32, "R10", "R10", 1'b0);

        // R7: start pulses during a run
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(2 * l + 1);
        run_req(2, "R7", "R7", 1'b1);
        for (int l = 0; l < LANES; l++) st_addr[l] = ADDR_W'(100);
        run_req(1, "R7", "R7", 1'b1);

        // R5: sweep of pseudo-random patterns, narrow and wide address ranges
        for (int it = 0; it < 160; it++) begin
            for (int l = 0; l < LANES; l++) begin
                logic [31:0] r;
                r = next_rnd();
                st_addr[l] = (it % 2 == 0) ? ADDR_W'(r % 96) : ADDR_W'(r % 1024);
            end
            st_valid = (it % 3 == 0) ? '1 : next_rnd();
            run_req(-1, "R5", "R1", it % 4 == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule